// File: doc/BRIEF.md
# Memory-Mapped 64-bit Machine Timer

This block is a machine timer peripheral for a single hart, reached through a simple 32-bit register port. It keeps a 64-bit time counter that advances only while the timer is switched on. A prescaler divides the clock by a programmable amount, and on each divided tick the counter adds a programmable step. A 64-bit compare value, written as two 32-bit halves, is compared against the counter.

The block drives two separate outputs. The first is a timer-pending level for the hart. It is high whenever the counter has reached the compare value, and no enable bit gates it. The second is an interrupt line for an external interrupt controller. It is driven by a sticky status bit, which is set by compare events or by a test write and masked by an enable bit. Software moves a deadline into the future by rewriting the compare value. That write withdraws both outputs.

The register offsets are fixed because software decodes them. All registers are one 32-bit word wide. Control is at 0x000, configuration at 0x100, the counter halves at 0x104 (low) and 0x108 (high), the compare halves at 0x10C (low) and 0x110 (high), interrupt enable at 0x114, interrupt status at 0x118 and interrupt test at 0x11C.

Top module: `hart_timer`

## Requirements
- R1: After reset these all read zero: control, configuration, interrupt enable, interrupt status and the counter. Both compare halves read 0xFFFFFFFF. `timer_pending_o` and `timer_irq_o` are low.
- R2: While control bit 0 is clear, the counter keeps its value.
- R3: While control bit 0 is set, the counter adds the step value (configuration bits 23:16) once every prescale+1 clock cycles (prescale is configuration bits 11:0). The first add lands prescale+1 cycles after the clock edge that sets the bit.
- R4: Offset 0x104 returns counter bits 31:0 and offset 0x108 returns counter bits 63:32. Writes to either offset are ignored.
- R5: The compare low half (0x10C) and high half (0x110) are each written and read back as 32-bit words.
- R6: `timer_pending_o` is high exactly when the compare value is less than or equal to the counter. It follows a register change by one clock edge, and neither the enable bit nor control bit 0 affects it.
- R7: Status bit 0 (0x118) is set on each clock edge at which three conditions all hold: the timer is on, the compare value has been reached, and enable bit 0 (0x114) is set. With the enable clear or the timer off, a compare match does not set it.
- R8: `timer_irq_o` equals status bit 0 AND enable bit 0.
- R9: Writing 1 to bit 0 of 0x118 clears the status bit. If a compare event sets the bit in the same cycle, the set wins.
- R10: Writing 1 to bit 0 of 0x11C sets the status bit at that edge, whatever the enable bit and control bit 0 hold. 0x11C always reads zero.
- R11: A write to either compare half that leaves the compare value above the counter clears the status bit. This takes priority over a compare event in the same cycle.
- R12: Offsets outside the map read zero. Writes to them change no register.
- R13: Control (0x000) stores only bit 0. Configuration (0x100) stores only bits 11:0 and 23:16. Interrupt enable (0x114) stores only bit 0. All other bits of these registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timer_pending_o | output | 1 | Timer-pending level to the hart |
| timer_irq_o | output | 1 | Enable-gated sticky interrupt line |

## Verification
Two pairs of updates to the sticky status bit can land in the same cycle. The first pair is a hardware compare event and a software write-1-to-clear. The bench provokes it by clearing the status while the counter sits past the compare value with the enable set; it expects the bit to stay 1. The second pair is a compare event and a compare rewrite into the future. The bench provokes it by writing a large compare high half while matching; it expects status, pending and interrupt all to be 0 on the next cycle.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned TIME_W   = 2 * DATA_W;
    localparam int unsigned OFF_W    = 12;
    localparam int unsigned PRE_W    = 12;
    localparam int unsigned STEP_W   = 8;
    localparam int unsigned STEP_LSB = 16;

    localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [OFF_W-1:0] OFF_CFG    = 12'h100;
    localparam logic [OFF_W-1:0] OFF_CNT_LO = 12'h104;
    localparam logic [OFF_W-1:0] OFF_CNT_HI = 12'h108;
    localparam logic [OFF_W-1:0] OFF_CMP_LO = 12'h10C;
    localparam logic [OFF_W-1:0] OFF_CMP_HI = 12'h110;
    localparam logic [OFF_W-1:0] OFF_IEN    = 12'h114;
    localparam logic [OFF_W-1:0] OFF_IST    = 12'h118;
    localparam logic [OFF_W-1:0] OFF_ITEST  = 12'h11C;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [PRE_W-1:0]  prescale;
    } tm_cfg_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CFG,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_IEN,
        SEL_IST,
        SEL_ITEST
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(logic [OFF_W-1:0] off);
        reg_sel_e s;
        case (off)
            OFF_CTRL:   s = SEL_CTRL;
            OFF_CFG:    s = SEL_CFG;
            OFF_CNT_LO: s = SEL_CNT_LO;
            OFF_CNT_HI: s = SEL_CNT_HI;
            OFF_CMP_LO: s = SEL_CMP_LO;
            OFF_CMP_HI: s = SEL_CMP_HI;
            OFF_IEN:    s = SEL_IEN;
            OFF_IST:    s = SEL_IST;
            OFF_ITEST:  s = SEL_ITEST;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(tm_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PRE_W-1:0]             = c.prescale;
        w[STEP_LSB +: STEP_W]    = c.step;
        return w;
    endfunction

    function automatic tm_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        tm_cfg_t c;
        c.prescale = w[PRE_W-1:0];
        c.step     = w[STEP_LSB +: STEP_W];
        return c;
    endfunction

endpackage

// File: rtl/hart_timer_prescaler.sv
module hart_timer_prescaler #(
    parameter int unsigned PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [PRE_W-1:0] prescale_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] div_q;

    // A prescale lowered mid-count still ticks at once thanks to >=.
    assign tick_o = run_i && (div_q >= prescale_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R3: back-to-back ticks only occur with a prescale of zero
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && $stable(prescale_i) && prescale_i != '0) |=> !tick_o);

endmodule

// File: rtl/hart_timer_counter.sv
module hart_timer_counter #(
    parameter int unsigned TIME_W = 64,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [TIME_W-1:0] count_o
);

    logic [TIME_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tick_i) begin
            count_q <= count_q + TIME_W'(step_i);
        end
    end

    assign count_o = count_q;

    // R3
    step_add_chk: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (count_o == $past(count_o) + TIME_W'($past(step_i))));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(count_o));

endmodule

// File: rtl/hart_timer_intr.sv
module hart_timer_intr (
    input  logic clk,
    input  logic rst,
    input  logic match_set_i,
    input  logic test_set_i,
    input  logic clear_i,
    input  logic retract_i,
    input  logic enable_i,
    output logic state_o,
    output logic irq_o
);

    logic state_q;

    // Retract beats any set; a set beats a software clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
        end else if (retract_i) begin
            state_q <= 1'b0;
        end else if (match_set_i || test_set_i) begin
            state_q <= 1'b1;
        end else if (clear_i) begin
            state_q <= 1'b0;
        end
    end

    assign state_o = state_q;
    assign irq_o   = state_q && enable_i;

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (match_set_i && clear_i && !retract_i) |=> state_o);

    // R10
    test_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (test_set_i && !retract_i) |=> state_o);

    // R11
    retract_clears_chk: assert property (@(posedge clk) disable iff (rst)
        retract_i |=> !state_o);

endmodule

// File: rtl/hart_timer.sv
module hart_timer
    import hart_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFF_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timer_pending_o,
    output logic              timer_irq_o
);

    reg_sel_e          sel;
    logic              wr;
    logic              run_q;
    tm_cfg_t           cfg_q;
    logic [TIME_W-1:0] cmp_q;
    logic [TIME_W-1:0] cmp_next;
    logic              ien_q;
    logic              tick;
    logic [TIME_W-1:0] mtime;
    logic              match;
    logic              cmp_wr;
    logic              retract;
    logic              state;

    assign sel = decode_offset(bus_addr);
    assign wr  = bus_valid && bus_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cfg_q <= '0;
            cmp_q <= '1;
            ien_q <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_CTRL:   run_q <= bus_wdata[0];
                SEL_CFG:    cfg_q <= word_to_cfg(bus_wdata);
                SEL_CMP_LO: cmp_q <= cmp_next;
                SEL_CMP_HI: cmp_q <= cmp_next;
                SEL_IEN:    ien_q <= bus_wdata[0];
                default:    ;
            endcase
        end
    end

    // Compare value as it will stand after this cycle's write.
    always_comb begin
        cmp_next = cmp_q;
        if (sel == SEL_CMP_LO) cmp_next[DATA_W-1:0]      = bus_wdata;
        if (sel == SEL_CMP_HI) cmp_next[TIME_W-1:DATA_W] = bus_wdata;
    end

    assign cmp_wr  = wr && (sel == SEL_CMP_LO || sel == SEL_CMP_HI);
    assign retract = cmp_wr && (cmp_next > mtime);

    hart_timer_prescaler #(.PRE_W(PRE_W)) i_prescaler (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run_q),
        .prescale_i (cfg_q.prescale),
        .tick_o     (tick)
    );

    hart_timer_counter #(.TIME_W(TIME_W), .STEP_W(STEP_W)) i_counter (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .step_i  (cfg_q.step),
        .count_o (mtime)
    );

    assign match           = (cmp_q <= mtime);
    assign timer_pending_o = match;

    hart_timer_intr i_intr (
        .clk         (clk),
        .rst         (rst),
        .match_set_i (run_q && match && ien_q),
        .test_set_i  (wr && sel == SEL_ITEST && bus_wdata[0]),
        .clear_i     (wr && sel == SEL_IST && bus_wdata[0]),
        .retract_i   (retract),
        .enable_i    (ien_q),
        .state_o     (state),
        .irq_o       (timer_irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL:   bus_rdata[0] = run_q;
            SEL_CFG:    bus_rdata    = cfg_to_word(cfg_q);
            SEL_CNT_LO: bus_rdata    = mtime[DATA_W-1:0];
            SEL_CNT_HI: bus_rdata    = mtime[TIME_W-1:DATA_W];
            SEL_CMP_LO: bus_rdata    = cmp_q[DATA_W-1:0];
            SEL_CMP_HI: bus_rdata    = cmp_q[TIME_W-1:DATA_W];
            SEL_IEN:    bus_rdata[0] = ien_q;
            SEL_IST:    bus_rdata[0] = state;
            default:    bus_rdata    = '0;
        endcase
    end

    // R2
    stopped_counter_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(mtime));

    // R11
    retract_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        retract |=> (!timer_irq_o && !timer_pending_o));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !ien_q |-> !timer_irq_o);

endmodule

// File: tb/test_hart_timer.sv
module test_hart_timer;
    import hart_timer_pkg::*;

    localparam int PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 25;
    // Register readback with the timer off; the last field is the requirement number.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h000, 32'h0000_0000, 8'd13},  // R13
        '{1'b1, 12'h000, 32'hFFFF_FFFE, 8'd13},
        '{1'b0, 12'h000, 32'h0000_0000, 8'd13},
        '{1'b1, 12'h100, 32'hFFFF_FFFF, 8'd13},
        '{1'b0, 12'h100, 32'h00FF_0FFF, 8'd13},
        '{1'b1, 12'h100, 32'h0000_0000, 8'd13},
        '{1'b0, 12'h100, 32'h0000_0000, 8'd13},
        '{1'b1, 12'h10C, 32'h1234_5678, 8'd5},   // R5
        '{1'b0, 12'h10C, 32'h1234_5678, 8'd5},
        '{1'b1, 12'h110, 32'h9ABC_DEF0, 8'd5},
        '{1'b0, 12'h110, 32'h9ABC_DEF0, 8'd5},
        '{1'b1, 12'h104, 32'hDEAD_BEEF, 8'd4},   // R4
        '{1'b0, 12'h104, 32'h0000_0000, 8'd4},
        '{1'b1, 12'h108, 32'h0000_0001, 8'd4},
        '{1'b0, 12'h108, 32'h0000_0000, 8'd4},
        '{1'b1, 12'h004, 32'hFFFF_FFFF, 8'd12},  // R12
        '{1'b0, 12'h004, 32'h0000_0000, 8'd12},
        '{1'b1, 12'h1FC, 32'h0000_0055, 8'd12},
        '{1'b0, 12'h1FC, 32'h0000_0000, 8'd12},
        '{1'b0, 12'h10C, 32'h1234_5678, 8'd12},
        '{1'b0, 12'h110, 32'h9ABC_DEF0, 8'd12},
        '{1'b0, 12'h000, 32'h0000_0000, 8'd12},
        '{1'b1, 12'h114, 32'hFFFF_FFFE, 8'd13},
        '{1'b0, 12'h114, 32'h0000_0000, 8'd13},
        '{1'b0, 12'h11C, 32'h0000_0000, 8'd10}   // R10
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_write;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        timer_pending_o;
    logic        timer_irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    hart_timer i_hart_timer (
        .clk             (clk),
        .rst             (rst),
        .bus_valid       (bus_valid),
        .bus_write       (bus_write),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .timer_pending_o (timer_pending_o),
        .timer_irq_o     (timer_irq_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    // Combinational read; takes 1 ns of the low phase.
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] v;
        rst = 1'b1;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr = '0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, r); check("R1 ctrl", r, 0);
        rd(12'h100, r); check("R1 cfg", r, 0);
        rd(12'h10C, r); check("R1 cmp lo", r, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(12'h110, r); check("R1 cmp hi", r, 32'hFFFF_FFFF);
        rd(12'h114, r); check("R1 ien", r, 0);
        rd(12'h118, r); check("R1 status", r, 0);
        @(negedge clk);
        rd(12'h104, r); check("R1 count lo", r, 0);
        rd(12'h108, r); check("R1 count hi", r, 0);
        check("R1 pending", timer_pending_o, 0);
        check("R1 irq", timer_irq_o, 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            if (VECS[i].wr) begin
                wr(VECS[i].addr, VECS[i].data);
            end else begin
                rd(VECS[i].addr, r);
                checks++;
                if (r !== VECS[i].data) begin
                    failures++;
                    $display("FAIL R%0d vector %0d addr 0x%0h actual=0x%0h expected=0x%0h",
                             VECS[i].req, i, VECS[i].addr, r, VECS[i].data);
                end
            end
        end
        @(negedge clk);

        // R3 prescale 3, step 5
        wr(12'h100, 32'h0005_0003);
        wr(12'h000, 32'h1);
        rd(12'h104, r); check("R3 count at start", r, 0);
        repeat (3) @(negedge clk);
        rd(12'h104, r); check("R3 no add before prescale+1", r, 0);
        @(negedge clk);
        rd(12'h104, r); check("R3 first add", r, 5);
        repeat (4) @(negedge clk);
        rd(12'h104, r); check("R3 second add", r, 10);
        @(negedge clk);

        // R2 stopped counter holds
        wr(12'h000, 32'h0);
        rd(12'h104, v);
        repeat (10) @(negedge clk);
        rd(12'h104, r); check("R2 hold while off", r, v);
        @(negedge clk);

        // R3 prescale 0, step 1
        wr(12'h100, 32'h0001_0000);
        wr(12'h000, 32'h1);
        rd(12'h104, r); check("R3 p0 start", r, v);
        @(negedge clk);
        rd(12'h104, r); check("R3 p0 one cycle", r, v + 1);
        repeat (3) @(negedge clk);
        rd(12'h104, r); check("R3 p0 four cycles", r, v + 4);
        @(negedge clk);
        wr(12'h000, 32'h0);
        rd(12'h104, v);
        @(negedge clk);

        // R6 pending vs compare with the timer off
        wr(12'h110, 32'h0);
        wr(12'h114, 32'h1);
        wr(12'h10C, v + 1);
        check("R6 future compare no pending", timer_pending_o, 0);
        wr(12'h10C, v);
        check("R6 reached compare pending", timer_pending_o, 1);
        rd(12'h118, r); check("R7 no event while off", r, 0);
        @(negedge clk);

        // R7 enable clear: no status, pending still high
        wr(12'h114, 32'h0);
        wr(12'h000, 32'h1);
        repeat (2) @(negedge clk);
        rd(12'h118, r); check("R7 masked match no status", r, 0);
        check("R6 pending ignores enable", timer_pending_o, 1);
        check("R8 irq low when masked", timer_irq_o, 0);

        // R7 and R8 enable set
        wr(12'h114, 32'h1);
        @(negedge clk);
        rd(12'h118, r); check("R7 status set", r, 1);
        check("R8 irq high", timer_irq_o, 1);
        @(negedge clk);

        // R9 clear collides with ongoing match: set wins
        wr(12'h118, 32'h1);
        rd(12'h118, r); check("R9 set beats clear", r, 1);
        @(negedge clk);

        // R11 rewrite compare into future
        wr(12'h110, 32'hFFFF_FFFF);
        rd(12'h118, r); check("R11 status cleared", r, 0);
        check("R11 pending low", timer_pending_o, 0);
        check("R11 irq low", timer_irq_o, 0);
        @(negedge clk);

        // R10 test write, then R9 plain clear
        wr(12'h11C, 32'h1);
        rd(12'h118, r); check("R10 test sets status", r, 1);
        check("R10 irq via test", timer_irq_o, 1);
        rd(12'h11C, r); check("R10 test reads zero", r, 0);
        @(negedge clk);
        wr(12'h118, 32'h1);
        rd(12'h118, r); check("R9 clear", r, 0);
        check("R9 irq low after clear", timer_irq_o, 0);
        @(negedge clk);
        wr(12'h114, 32'h0);
        wr(12'h11C, 32'h1);
        rd(12'h118, r); check("R10 test with enable clear", r, 1);
        check("R8 irq gated by enable", timer_irq_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule